// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital sequencer of a successive-approximation voltmeter. A start pulse opens a measurement. The block first closes an external sample/hold switch for a programmable number of acquisition clocks. It then opens the switch and decides the bits of an approximation code one at a time, most significant first. An external DAC turns the code into a fraction of the reference (code/2^WIDTH). An external comparator reports whether the held input lies above that level.

A one-hot ring counter marks the bit under trial. Each trial takes two clocks. In the first clock the trial bit is raised and the DAC and comparator settle. In the second clock the comparator is sampled: the trial bit is kept or dropped, and the next lower bit is raised. When the ring counter reaches its last position, the controller stops. It emits a one-clock completion strobe and latches the final code into a registered result for a readout stage. The analog parts, the reference and the display decoding lie outside the block.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A synchronous active-low reset, applied at any time, leaves dac_code_o, result_o, busy_o, done_o, sample_o and hold_o all at 0 after the clock edge that samples it.
- R2: A start_i sampled high while busy_o is low gives, one clock later, dac_code_o equal to only the top bit set (0x80 for WIDTH=8), with busy_o and sample_o high.
- R3: sample_o stays high for exactly ACQ_CYCLES clocks from the one after start. hold_o then rises in the next clock and stays high until the completion strobe. sample_o and hold_o are never high together.
- R4: Bits are tried from the top bit down to bit 0, two clocks per bit. In the first clock of the trial for bit p, dac_code_o has bit p set and every bit below p clear. The bits above p carry the decisions already made.
- R5: A trial bit is kept when cmp_above_i is high in the second clock of its trial and is cleared otherwise. The final code is therefore the largest code whose DAC level lies strictly below the held input.
- R6: done_o is high for exactly one clock, ACQ_CYCLES + 2*WIDTH clocks after the start clock. In that same clock busy_o is low and result_o and dac_code_o show the final code.
- R7: A start_i pulse that arrives while busy_o is high has no effect on the code sequence, on the sample/hold control or on the time of completion.
- R8: result_o changes only in a clock where done_o is high. It holds its value through idle time and through the whole of the next measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start a measurement (taken only while idle) |
| cmp_above_i | input | 1 | Comparator: held input is above the DAC level |
| dac_code_o | output | WIDTH | Approximation code driven to the DAC |
| sample_o | output | 1 | Sample/hold switch closed (acquire) |
| hold_o | output | 1 | Sample/hold switch open (hold during bit trials) |
| busy_o | output | 1 | Measurement in progress |
| done_o | output | 1 | One-clock strobe: final code is ready |
| result_o | output | WIDTH | Registered final code for the readout |

## Verification
Timing is counted from the clock edge that samples start_i. The loaded code and the sample flag are due one clock after that edge. The trial for bit 7-i begins ACQ_CYCLES + 2i clocks after it, and the strobe with the result comes ACQ_CYCLES + 2*WIDTH clocks after it. The bench steps clock by clock on falling edges and compares each output in exactly the clock where the requirement places its change. Expected codes come from a closed form on the held input value, (v-1)/16 for a 12-bit analog model. The model also keeps the held value apart from the live input, so an input that moves during the hold phase must not alter the result.

// File: rtl/sar_pkg.sv
// Package sar_pkg
// Shared types for the successive-approximation controller.
// Assumes: a single clock domain; all state is reset synchronously.
package sar_pkg;

    // Phases of one measurement
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,  // waiting for start
        ST_ACQ    = 2'd1,  // sample switch closed, input settling
        ST_SET    = 2'd2,  // trial bit raised, DAC/comparator settling
        ST_DECIDE = 2'd3   // comparator sampled, keep or drop the trial bit
    } sar_state_e;

endpackage

// File: rtl/sar_acq_timer.sv
// Module sar_acq_timer
// Counts the acquisition window that follows a start.
// expired_o is high in the last clock of a run of ACQ_CYCLES clocks.
// Assumes: ACQ_CYCLES >= 1; clear_i restarts the count from zero.
module sar_acq_timer #(
    parameter int ACQ_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = (ACQ_CYCLES < 2) ? 1 : $clog2(ACQ_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(ACQ_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Count the clocks spent in the acquisition window
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (run_i && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Flag the final acquisition clock
    always_comb begin
        expired_o = run_i && (cnt_q == LAST);
    end

endmodule

// File: rtl/sar_ring.sv
// Module sar_ring
// One-hot ring counter that marks the bit under trial.
// load_i places the token on the top bit; advance_i moves it one bit down.
// last_o is high while the token sits on bit 0.
// Assumes: load_i and advance_i are never high together.
module sar_ring #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             advance_i,
    output logic [WIDTH-1:0] ring_o,
    output logic             last_o
);
    localparam logic [WIDTH-1:0] TOP = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] ring_q;

    // Move the trial token from the top bit toward bit 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_q <= '0;
        end else if (load_i) begin
            ring_q <= TOP;
        end else if (advance_i) begin
            ring_q <= ring_q >> 1;
        end
    end

    // Export the token and the end-of-ring flag
    always_comb begin
        ring_o = ring_q;
        last_o = ring_q[0];
    end

    // R4: the token is never duplicated
    assert_ring_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ring_q));

    // R4: a step moves the token exactly one bit down
    assert_ring_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && !load_i && ring_q != '0) |=> (ring_q == ($past(ring_q) >> 1)));

endmodule

// File: rtl/sar_trial_reg.sv
// Module sar_trial_reg
// Approximation register. On load it holds only the top bit.
// On decide it keeps or clears the bit marked by ring_i, according to
// cmp_i, and raises the next lower bit for the following trial.
// code_next_o exposes the value the register takes at the next edge.
// Assumes: ring_i is one-hot whenever decide_i is high.
module sar_trial_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             decide_i,
    input  logic             cmp_i,
    input  logic [WIDTH-1:0] ring_i,
    output logic [WIDTH-1:0] code_o,
    output logic [WIDTH-1:0] code_next_o
);
    localparam logic [WIDTH-1:0] TOP = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] code_q;
    logic [WIDTH-1:0] code_d;

    // Next code: seed the top bit, or resolve the trial bit and raise the next one
    always_comb begin
        code_d = code_q;
        if (load_i) begin
            code_d = TOP;
        end else if (decide_i) begin
            if (!cmp_i) begin
                code_d = code_q & ~ring_i;
            end
            code_d = code_d | (ring_i >> 1);
        end
    end

    // Register the approximation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else begin
            code_q <= code_d;
        end
    end

    // Drive the outputs
    always_comb begin
        code_o      = code_q;
        code_next_o = code_d;
    end

    // R5: an input above the level keeps the trial bit
    assert_keep_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (decide_i && !load_i && cmp_i) |=> ((code_q & $past(ring_i)) != '0));

    // R5: an input not above the level drops the trial bit
    assert_drop_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (decide_i && !load_i && !cmp_i) |=> ((code_q & $past(ring_i)) == '0));

endmodule

// File: rtl/sar_conv_ctrl.sv
// Module sar_conv_ctrl (top)
// Sequencer of a successive-approximation measurement: acquisition window
// with the sample switch closed, then WIDTH two-clock bit trials with the
// switch open, then a one-clock done strobe and a registered result.
// Assumes: cmp_above_i is valid within one clock of a dac_code_o change;
// start_i is ignored while busy_o is high.
module sar_conv_ctrl #(
    parameter int WIDTH      = 8,
    parameter int ACQ_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmp_above_i,
    output logic [WIDTH-1:0] dac_code_o,
    output logic             sample_o,
    output logic             hold_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] result_o
);
    import sar_pkg::*;

    localparam logic [WIDTH-1:0] TOP = {1'b1, {(WIDTH-1){1'b0}}};

    sar_state_e       state_q;
    sar_state_e       state_d;
    logic             done_q;
    logic [WIDTH-1:0] result_q;
    logic             accept;
    logic             acq_expired;
    logic             decide;
    logic             ring_last;
    logic [WIDTH-1:0] ring;
    logic [WIDTH-1:0] code;
    logic [WIDTH-1:0] code_next;
    logic             armed_q;

    // Start is accepted only while idle
    always_comb begin
        accept = (state_q == ST_IDLE) && start_i;
        decide = (state_q == ST_DECIDE);
    end

    // Acquisition window timer
    sar_acq_timer #(.ACQ_CYCLES(ACQ_CYCLES)) u_acq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (accept),
        .run_i     (state_q == ST_ACQ),
        .expired_o (acq_expired)
    );

    // Trial-bit ring counter
    sar_ring #(.WIDTH(WIDTH)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept),
        .advance_i (decide && !ring_last),
        .ring_o    (ring),
        .last_o    (ring_last)
    );

    // Approximation register
    sar_trial_reg #(.WIDTH(WIDTH)) u_code (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (accept),
        .decide_i    (decide),
        .cmp_i       (cmp_above_i),
        .ring_i      (ring),
        .code_o      (code),
        .code_next_o (code_next)
    );

    // Phase sequencing
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_ACQ;
            ST_ACQ:    if (acq_expired) state_d = ST_SET;
            ST_SET:    state_d = ST_DECIDE;
            ST_DECIDE: state_d = ring_last ? ST_IDLE : ST_SET;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Completion strobe and result capture on the last decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            result_q <= '0;
        end else begin
            done_q <= decide && ring_last;
            if (decide && ring_last) begin
                result_q <= code_next;
            end
        end
    end

    // Marks that at least one clock has passed since reset (assertion history)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
        end
    end

    // Drive the outputs from registered state
    always_comb begin
        dac_code_o = code;
        sample_o   = (state_q == ST_ACQ);
        hold_o     = (state_q == ST_SET) || (state_q == ST_DECIDE);
        busy_o     = (state_q != ST_IDLE);
        done_o     = done_q;
        result_o   = result_q;
    end

    // R2: an accepted start loads the top bit and opens the sample window
    assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (dac_code_o == TOP && sample_o && busy_o));

    // R3: sample and hold are exclusive
    assert_sh_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_o && hold_o));

    // R3: hold begins straight after the sample window
    assert_hold_after_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $rose(hold_o)) |-> $past(sample_o));

    // R4: during settling only the trial bit is set among the undecided bits
    assert_lower_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SET) |-> ((code & ring) != '0 && (code & (ring - 1'b1)) == '0));

    // R6: the completion strobe lasts one clock and ends the busy period
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && result_o == dac_code_o));

    // R7: a start during a bit trial does not reopen the acquisition window
    assert_busy_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && hold_o) |=> !sample_o);

    // R8: the result moves only with the completion strobe
    assert_result_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !done_o) |-> $stable(result_o));

endmodule

// File: tb/sar_conv_ctrl_tb.sv
`timescale 1ns/1ps
module sar_conv_ctrl_tb;
    localparam int W   = 8;
    localparam int ACQ = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         cmp_above;
    logic [W-1:0] dac_code;
    logic         sample;
    logic         hold;
    logic         busy;
    logic         done;
    logic [W-1:0] result;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    // Analog environment: 12-bit input, DAC level = code*16
    int vin_live = 0;
    int vin_held = 0;

    always #2.5 clk = ~clk;

    sar_conv_ctrl #(.WIDTH(W), .ACQ_CYCLES(ACQ)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .cmp_above_i (cmp_above),
        .dac_code_o  (dac_code),
        .sample_o    (sample),
        .hold_o      (hold),
        .busy_o      (busy),
        .done_o      (done),
        .result_o    (result)
    );

    // Sample/hold capacitor follows the input while the switch is closed
    always @(posedge clk) if (sample) vin_held <= vin_live;
    assign cmp_above = (vin_held > int'(dac_code) * 16);

    function automatic int exp_code(input int v);
        return (v <= 0) ? 0 : ((v - 1) / 16);
    endfunction

    function automatic int exp_trial(input int fin, input int i);
        int upper;
        upper = (fin >> (W - i)) << (W - i);
        return upper | (1 << (W - 1 - i));
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One full measurement, stepped and checked clock by clock
    task automatic run_conv(input int v, input bit scramble, input bit inject);
        int fin;
        int prev_res;
        fin = exp_code(v);
        prev_res = int'(result);
        @(negedge clk);
        vin_live = v;
        start = 1'b1;
        @(negedge clk);            // clock 0 after the start edge
        start = 1'b0;
        chk(int'(dac_code) == (1 << (W - 1)), "R2", "loaded code", int'(dac_code), 1 << (W - 1));
        chk(busy && sample && !hold, "R2", "busy/sample after start", {busy, sample, hold}, 3'b110);
        for (int c = 1; c < ACQ; c++) begin
            if (inject && c == 1) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(sample && !hold, "R3", "acquisition window", {sample, hold}, 2'b10);
        end
        for (int i = 0; i < W; i++) begin
            @(negedge clk);        // settling clock of trial i
            chk(hold && !sample, "R3", "hold during trial", {sample, hold}, 2'b01);
            chk(int'(dac_code) == exp_trial(fin, i), "R4", "trial code", int'(dac_code), exp_trial(fin, i));
            chk(!done && int'(result) == prev_res, "R8", "result before done", int'(result), prev_res);
            if (inject && i == 3) start = 1'b1;
            if (scramble && i == 0) vin_live = int'($urandom_range(0, 4095));
            @(negedge clk);        // decision clock of trial i
            start = 1'b0;
            if (inject) chk(hold && !sample, "R7", "start while busy ignored", {sample, hold}, 2'b01);
        end
        @(negedge clk);            // ACQ + 2*W clocks after the start edge
        chk(done && !busy, "R6", "done strobe", {done, busy}, 2'b10);
        chk(int'(result) == fin, "R5", "final code", int'(result), fin);
        chk(int'(dac_code) == fin, "R6", "dac code at done", int'(dac_code), fin);
        chk(!sample && !hold, "R3", "switch idle at done", {sample, hold}, 2'b00);
        @(negedge clk);
        chk(!done, "R6", "done one clock", int'(done), 0);
        vin_live = int'($urandom_range(0, 4095));
        @(negedge clk);
        chk(int'(result) == fin, "R8", "result held in idle", int'(result), fin);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5A17;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(dac_code == 0 && result == 0 && !busy && !done && !sample && !hold,
            "R1", "reset state", {busy, done, sample, hold}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !sample, "R1", "idle without start", {busy, sample}, 0);

        // Directed corners (input values near code boundaries and extremes)
        run_conv(0, 1'b0, 1'b0);
        run_conv(1, 1'b0, 1'b0);
        run_conv(16, 1'b0, 1'b0);
        run_conv(17, 1'b0, 1'b0);
        run_conv(2048, 1'b0, 1'b0);
        run_conv(2049, 1'b0, 1'b0);
        run_conv(4095, 1'b0, 1'b0);
        run_conv(1000, 1'b1, 1'b1);   // R7 start while busy, moving input

        // Random measurements
        for (int k = 0; k < 24; k++) begin
            run_conv(int'($urandom_range(0, 4095)), 1'($urandom % 2), ($urandom % 3) == 0);
        end

        // R1: reset in the middle of a measurement
        @(negedge clk);
        vin_live = 3000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (8) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(dac_code == 0 && result == 0 && !busy && !done && !sample && !hold,
            "R1", "reset during trials", {busy, done, sample, hold}, 0);
        rst_n = 1'b1;
        run_conv(3000, 1'b0, 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule